// File: doc/BRIEF.md
# Blit Command Packet Decoder

This block sits behind a command FIFO and turns a stream of 32-bit command words into complete two-dimensional blit descriptors. It accepts two packet kinds. A source-copy packet is eight words long. A solid color-fill packet is six words long. The opcode in the first word sets the packet length. The block pulls out the write-enable flags, the raster operation, the color depth, the corners of the destination rectangle, the surface pitches and the base addresses. For a fill packet it also pulls out the fill value.

Pitches are 16-bit signed byte counts. A surface marked tiled stores its pitch in 4-byte units, and the decoder scales that pitch to bytes. A rectangle with no area is dropped without a descriptor. A tiled surface whose base address is not on a 4 KiB boundary is reported as an error. A first word with an unrecognised opcode is reported as an error and discarded. Descriptors leave on a valid/ready port. While a descriptor waits to be taken, no further input words are consumed. Memory access, relocation and pixel work belong to downstream blocks.

Top module: `blit_pkt_decoder`

## Requirements
- R1: After reset, `desc_valid`, `err_opcode` and `err_align` are 0 and `in_ready` is 1.
- R2: A packet whose first word has bits 31:24 equal to `OPC_COPY` (default 8'hC3) takes eight words, in this order:
  - command word;
  - format word;
  - destination corner (x1,y1);
  - destination corner (x2,y2);
  - destination address;
  - source origin;
  - source pitch;
  - source address.

  The resulting descriptor has `d_is_copy`=1 and `d_fill_color`=0.
- R3: A packet with opcode `OPC_FILL` (default 8'hA5) takes six words. Word 5 is the fill value. For this kind, the outputs `d_src_x`, `d_src_y`, `d_src_pitch`, `d_src_addr` and `d_src_tiled` are 0, even when command bit 15 is set.
- R4: The command and format words decode as follows:
  - In a corner or origin word, Y is bits 31:16 and X is bits 15:0.
  - In the command word, bit 21 is the alpha write-enable, bit 20 is the RGB write-enable, bit 15 is the source-tiled flag and bit 11 is the destination-tiled flag.
  - In the format word, bits 23:16 are the raster-op code, bits 25:24 are the depth code and bits 15:0 are the signed destination pitch.
  - A pitch is sign-extended to 18 bits.
- R5: When a surface is tiled, its output pitch equals the stored 16-bit signed pitch times 4.
- R6: If x2 ≤ x1 or y2 ≤ y1 (signed 16-bit compare), the packet completes without a descriptor and without an error.
- R7: If a tiled surface has a base address with bits 11:0 not all zero, `err_align` pulses for exactly one cycle and no descriptor is issued. This check takes precedence over R6.
- R8: If the first word of a packet has an opcode that is neither `OPC_COPY` nor `OPC_FILL`, `err_opcode` pulses for one cycle and the word is discarded. The next word is decoded as a command word.
- R9: While `desc_valid`=1 and `desc_ready`=0, the descriptor outputs do not change and `in_ready`=0.
- R10: After the edge that accepts a packet's last word, `in_ready` drops at once. `desc_valid` rises at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command word available |
| in_ready | output | 1 | Decoder takes a word this cycle |
| in_word | input | 32 | Command word |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Consumer takes the descriptor |
| d_is_copy | output | 1 | 1 for a source copy, 0 for a fill |
| d_wr_alpha | output | 1 | Alpha channel write enable |
| d_wr_rgb | output | 1 | RGB channels write enable |
| d_src_tiled | output | 1 | Source surface tiled |
| d_dst_tiled | output | 1 | Destination surface tiled |
| d_rop | output | 8 | Raster-op code |
| d_depth | output | 2 | Color depth code |
| d_dst_pitch | output | 18 | Destination pitch in bytes, signed |
| d_dst_x1 | output | 16 | Destination left |
| d_dst_y1 | output | 16 | Destination top |
| d_dst_x2 | output | 16 | Destination right, exclusive |
| d_dst_y2 | output | 16 | Destination bottom, exclusive |
| d_dst_addr | output | 32 | Destination base address |
| d_src_x | output | 16 | Source origin X |
| d_src_y | output | 16 | Source origin Y |
| d_src_pitch | output | 18 | Source pitch in bytes, signed |
| d_src_addr | output | 32 | Source base address |
| d_fill_color | output | 32 | Fill value |
| err_opcode | output | 1 | Unknown opcode pulse |
| err_align | output | 1 | Misaligned tiled surface pulse |

## Verification
A word counter that drifts by one slot shows at the ports on the very next descriptor. Fields arrive shifted, or a fill swallows the command word of the following packet. The mismatch then carries on through every later descriptor, so one random packet stream exposes it within a few packets. A kind register that latches the wrong packet type moves the fill value into the source fields, which is visible in the first fill descriptor. A wrong completion decision shows up when the count of issued descriptors, or of error pulses, departs from the bench's model. The completion decisions are the empty-rectangle drop, the alignment error and their relative priority.

// File: rtl/blit_pkg.sv
`timescale 1ns/1ps
package blit_pkg;
   // packet word format
   localparam int WORD_W       = 32;
   localparam int HALF_W       = 16;
   localparam int OPC_W        = 8;
   localparam int OPC_LSB      = 24;
   localparam int ROP_W        = 8;
   localparam int ROP_LSB      = 16;
   localparam int DEPTH_W      = 2;
   localparam int DEPTH_LSB    = 24;
   localparam int BIT_WR_ALPHA = 21;
   localparam int BIT_WR_RGB   = 20;
   localparam int BIT_SRC_TILE = 15;
   localparam int BIT_DST_TILE = 11;
   // packet lengths and word slots
   localparam int COPY_WORDS   = 8;
   localparam int FILL_WORDS   = 6;
   localparam int IDX_W        = $clog2(COPY_WORDS);
   localparam int SLOT_CMD     = 0;
   localparam int SLOT_FMT     = 1;
   localparam int SLOT_DTL     = 2;
   localparam int SLOT_DBR     = 3;
   localparam int SLOT_DADR    = 4;
   localparam int SLOT_SORG    = 5;  // fill value for fill packets
   localparam int SLOT_SPIT    = 6;
   localparam int SLOT_SADR    = 7;

   typedef enum logic {PK_FILL = 1'b0, PK_COPY = 1'b1} pkt_kind_e;

   typedef struct packed {
      logic               wr_alpha;
      logic               wr_rgb;
      logic               src_tiled;
      logic               dst_tiled;
      logic [ROP_W-1:0]   rop;
      logic [DEPTH_W-1:0] depth;
      logic [HALF_W-1:0]  dst_pitch;
      logic [HALF_W-1:0]  dx1;
      logic [HALF_W-1:0]  dy1;
      logic [HALF_W-1:0]  dx2;
      logic [HALF_W-1:0]  dy2;
      logic [WORD_W-1:0]  dst_addr;
      logic [HALF_W-1:0]  sx;
      logic [HALF_W-1:0]  sy;
      logic [HALF_W-1:0]  src_pitch;
      logic [WORD_W-1:0]  src_addr;
      logic [WORD_W-1:0]  fill_color;
   } raw_pkt_t;
endpackage

// File: rtl/blit_word_seq.sv
`timescale 1ns/1ps
module blit_word_seq
   import blit_pkg::*;
#(
   parameter logic [OPC_W-1:0] OPC_COPY = 8'hC3,
   parameter logic [OPC_W-1:0] OPC_FILL = 8'hA5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             word_fire,
   input  logic [OPC_W-1:0] opcode,
   output logic [IDX_W-1:0] idx,
   output pkt_kind_e        kind,
   output logic             last_word,
   output logic             bad_op
);
   localparam logic [IDX_W-1:0] LAST_COPY = IDX_W'(COPY_WORDS - 1);
   localparam logic [IDX_W-1:0] LAST_FILL = IDX_W'(FILL_WORDS - 1);

   logic [IDX_W-1:0] idx_q;
   pkt_kind_e        kind_q;
   logic             bad_q;
   logic [IDX_W-1:0] last_idx;
   logic             opc_copy, opc_fill;

   assign opc_copy  = (opcode == OPC_COPY);
   assign opc_fill  = (opcode == OPC_FILL);
   assign last_idx  = (kind_q == PK_COPY) ? LAST_COPY : LAST_FILL;
   assign last_word = word_fire && (idx_q != '0) && (idx_q == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         kind_q <= PK_FILL;
         bad_q  <= 1'b0;
      end else begin
         bad_q <= 1'b0;
         if (word_fire) begin
            if (idx_q == '0) begin
               if (opc_copy) begin
                  kind_q <= PK_COPY;
                  idx_q  <= IDX_W'(1);
               end else if (opc_fill) begin
                  kind_q <= PK_FILL;
                  idx_q  <= IDX_W'(1);
               end else begin
                  bad_q  <= 1'b1;
               end
            end else if (idx_q == last_idx) begin
               idx_q <= '0;
            end else begin
               idx_q <= idx_q + IDX_W'(1);
            end
         end
      end
   end

   assign idx    = idx_q;
   assign kind   = kind_q;
   assign bad_op = bad_q;

   // R8: a rejected command word leaves the sequencer waiting for a command
   a_r8_resync: assert property (@(posedge clk) disable iff (!rst_n)
      bad_q |-> (idx_q == '0));
   // R3: a fill packet never reaches the copy-only slots
   a_r3_fill_len: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == PK_FILL) |-> (idx_q < IDX_W'(FILL_WORDS)));
endmodule

// File: rtl/blit_field_capture.sv
`timescale 1ns/1ps
module blit_field_capture
   import blit_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_fire,
   input  logic [IDX_W-1:0]  idx,
   input  pkt_kind_e         kind,
   input  logic [WORD_W-1:0] word,
   output raw_pkt_t          pkt
);
   raw_pkt_t pkt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkt_q <= '0;
      end else if (word_fire) begin
         case (int'(idx))
            SLOT_CMD: begin
               pkt_q.wr_alpha   <= word[BIT_WR_ALPHA];
               pkt_q.wr_rgb     <= word[BIT_WR_RGB];
               pkt_q.src_tiled  <= word[BIT_SRC_TILE];
               pkt_q.dst_tiled  <= word[BIT_DST_TILE];
               pkt_q.sx         <= '0;
               pkt_q.sy         <= '0;
               pkt_q.src_pitch  <= '0;
               pkt_q.src_addr   <= '0;
               pkt_q.fill_color <= '0;
            end
            SLOT_FMT: begin
               pkt_q.rop       <= word[ROP_LSB +: ROP_W];
               pkt_q.depth     <= word[DEPTH_LSB +: DEPTH_W];
               pkt_q.dst_pitch <= word[HALF_W-1:0];
            end
            SLOT_DTL: begin
               pkt_q.dx1 <= word[HALF_W-1:0];
               pkt_q.dy1 <= word[WORD_W-1:HALF_W];
            end
            SLOT_DBR: begin
               pkt_q.dx2 <= word[HALF_W-1:0];
               pkt_q.dy2 <= word[WORD_W-1:HALF_W];
            end
            SLOT_DADR: pkt_q.dst_addr <= word;
            SLOT_SORG: begin
               if (kind == PK_COPY) begin
                  pkt_q.sx <= word[HALF_W-1:0];
                  pkt_q.sy <= word[WORD_W-1:HALF_W];
               end else begin
                  pkt_q.fill_color <= word;
               end
            end
            SLOT_SPIT: pkt_q.src_pitch <= word[HALF_W-1:0];
            SLOT_SADR: pkt_q.src_addr  <= word;
            default: ;
         endcase
      end
   end

   assign pkt = pkt_q;
endmodule

// File: rtl/blit_desc_check.sv
`timescale 1ns/1ps
module blit_desc_check
   import blit_pkg::*;
#(
   parameter int TILE_PITCH_LOG2 = 2,
   parameter int TILE_ALIGN_LOG2 = 12,
   parameter bit COORD_SIGNED    = 1'b1,
   localparam int PITCH_OUT_W    = HALF_W + TILE_PITCH_LOG2
)(
   input  logic                   is_copy,
   input  logic                   dst_tiled,
   input  logic                   src_tiled_raw,
   input  logic [HALF_W-1:0]      dst_pitch_raw,
   input  logic [HALF_W-1:0]      src_pitch_raw,
   input  logic [WORD_W-1:0]      dst_addr,
   input  logic [WORD_W-1:0]      src_addr,
   input  logic [HALF_W-1:0]      dx1,
   input  logic [HALF_W-1:0]      dy1,
   input  logic [HALF_W-1:0]      dx2,
   input  logic [HALF_W-1:0]      dy2,
   output logic [PITCH_OUT_W-1:0] dst_pitch,
   output logic [PITCH_OUT_W-1:0] src_pitch,
   output logic                   src_tiled,
   output logic                   empty,
   output logic                   misaligned
);
   localparam int N_SURF = 2;  // 0: destination, 1: source

   logic [N_SURF-1:0]      surf_tiled;
   logic [N_SURF-1:0]      surf_bad;
   logic [HALF_W-1:0]      surf_praw [N_SURF];
   logic [WORD_W-1:0]      surf_addr [N_SURF];
   logic [PITCH_OUT_W-1:0] surf_pout [N_SURF];

   assign src_tiled     = is_copy & src_tiled_raw;
   assign surf_tiled    = {src_tiled, dst_tiled};
   assign surf_praw[0]  = dst_pitch_raw;
   assign surf_praw[1]  = src_pitch_raw;
   assign surf_addr[0]  = dst_addr;
   assign surf_addr[1]  = src_addr;

   for (genvar s = 0; s < N_SURF; s++) begin : g_surf
      // tiled pitch is stored in 2**TILE_PITCH_LOG2-byte units
      assign surf_pout[s] = surf_tiled[s]
         ? {surf_praw[s], {TILE_PITCH_LOG2{1'b0}}}
         : {{TILE_PITCH_LOG2{surf_praw[s][HALF_W-1]}}, surf_praw[s]};
      assign surf_bad[s]  = surf_tiled[s] && (surf_addr[s][TILE_ALIGN_LOG2-1:0] != '0);
   end

   assign dst_pitch  = surf_pout[0];
   assign src_pitch  = surf_pout[1];
   assign misaligned = |surf_bad;

   if (COORD_SIGNED) begin : g_cmp_signed
      assign empty = ($signed(dx2) <= $signed(dx1)) || ($signed(dy2) <= $signed(dy1));
   end else begin : g_cmp_unsigned
      assign empty = (dx2 <= dx1) || (dy2 <= dy1);
   end
endmodule

// File: rtl/blit_pkt_decoder.sv
`timescale 1ns/1ps
module blit_pkt_decoder
   import blit_pkg::*;
#(
   parameter logic [OPC_W-1:0] OPC_COPY  = 8'hC3,
   parameter logic [OPC_W-1:0] OPC_FILL  = 8'hA5,
   parameter int TILE_PITCH_LOG2         = 2,
   parameter int TILE_ALIGN_LOG2         = 12,
   parameter bit COORD_SIGNED            = 1'b1,
   localparam int PITCH_OUT_W            = HALF_W + TILE_PITCH_LOG2
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [WORD_W-1:0]      in_word,
   output logic                   desc_valid,
   input  logic                   desc_ready,
   output logic                   d_is_copy,
   output logic                   d_wr_alpha,
   output logic                   d_wr_rgb,
   output logic                   d_src_tiled,
   output logic                   d_dst_tiled,
   output logic [ROP_W-1:0]       d_rop,
   output logic [DEPTH_W-1:0]     d_depth,
   output logic [PITCH_OUT_W-1:0] d_dst_pitch,
   output logic [HALF_W-1:0]      d_dst_x1,
   output logic [HALF_W-1:0]      d_dst_y1,
   output logic [HALF_W-1:0]      d_dst_x2,
   output logic [HALF_W-1:0]      d_dst_y2,
   output logic [WORD_W-1:0]      d_dst_addr,
   output logic [HALF_W-1:0]      d_src_x,
   output logic [HALF_W-1:0]      d_src_y,
   output logic [PITCH_OUT_W-1:0] d_src_pitch,
   output logic [WORD_W-1:0]      d_src_addr,
   output logic [WORD_W-1:0]      d_fill_color,
   output logic                   err_opcode,
   output logic                   err_align
);
   // elaboration checks
   if (OPC_COPY == OPC_FILL) begin : g_chk_opc
      $error("blit_pkt_decoder: the two opcodes must differ");
   end
   if (TILE_PITCH_LOG2 < 1 || TILE_PITCH_LOG2 > 8) begin : g_chk_tpitch
      $error("blit_pkt_decoder: TILE_PITCH_LOG2 out of range");
   end
   if (TILE_ALIGN_LOG2 < 1 || TILE_ALIGN_LOG2 >= WORD_W) begin : g_chk_talign
      $error("blit_pkt_decoder: TILE_ALIGN_LOG2 out of range");
   end

   logic             word_fire;
   logic [IDX_W-1:0] idx;
   pkt_kind_e        kind;
   logic             last_word;
   logic             bad_op;
   raw_pkt_t         pkt;
   logic             empty, misaligned, src_tiled_eff;
   logic             done_q, valid_q, align_q;

   assign in_ready  = !valid_q && !done_q;
   assign word_fire = in_valid && in_ready;

   blit_word_seq #(
      .OPC_COPY (OPC_COPY),
      .OPC_FILL (OPC_FILL)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_fire (word_fire),
      .opcode    (in_word[OPC_LSB +: OPC_W]),
      .idx       (idx),
      .kind      (kind),
      .last_word (last_word),
      .bad_op    (bad_op)
   );

   blit_field_capture i_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_fire (word_fire),
      .idx       (idx),
      .kind      (kind),
      .word      (in_word),
      .pkt       (pkt)
   );

   blit_desc_check #(
      .TILE_PITCH_LOG2 (TILE_PITCH_LOG2),
      .TILE_ALIGN_LOG2 (TILE_ALIGN_LOG2),
      .COORD_SIGNED    (COORD_SIGNED)
   ) i_chk (
      .is_copy       (kind == PK_COPY),
      .dst_tiled     (pkt.dst_tiled),
      .src_tiled_raw (pkt.src_tiled),
      .dst_pitch_raw (pkt.dst_pitch),
      .src_pitch_raw (pkt.src_pitch),
      .dst_addr      (pkt.dst_addr),
      .src_addr      (pkt.src_addr),
      .dx1           (pkt.dx1),
      .dy1           (pkt.dy1),
      .dx2           (pkt.dx2),
      .dy2           (pkt.dy2),
      .dst_pitch     (d_dst_pitch),
      .src_pitch     (d_src_pitch),
      .src_tiled     (src_tiled_eff),
      .empty         (empty),
      .misaligned    (misaligned)
   );

   // completion: one cycle after the last word, decide issue, drop or error
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         valid_q <= 1'b0;
         align_q <= 1'b0;
      end else begin
         done_q  <= last_word;
         align_q <= done_q && misaligned;
         if (done_q && !misaligned && !empty) begin
            valid_q <= 1'b1;
         end else if (desc_ready) begin
            valid_q <= 1'b0;
         end
      end
   end

   assign desc_valid   = valid_q;
   assign err_opcode   = bad_op;
   assign err_align    = align_q;
   assign d_is_copy    = (kind == PK_COPY);
   assign d_wr_alpha   = pkt.wr_alpha;
   assign d_wr_rgb     = pkt.wr_rgb;
   assign d_src_tiled  = src_tiled_eff;
   assign d_dst_tiled  = pkt.dst_tiled;
   assign d_rop        = pkt.rop;
   assign d_depth      = pkt.depth;
   assign d_dst_x1     = pkt.dx1;
   assign d_dst_y1     = pkt.dy1;
   assign d_dst_x2     = pkt.dx2;
   assign d_dst_y2     = pkt.dy2;
   assign d_dst_addr   = pkt.dst_addr;
   assign d_src_x      = pkt.sx;
   assign d_src_y      = pkt.sy;
   assign d_src_addr   = pkt.src_addr;
   assign d_fill_color = pkt.fill_color;

   // R9: a waiting descriptor is held and blocks the input
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && !desc_ready) |=> (desc_valid && $stable(d_dst_addr)
         && $stable(d_dst_x1) && $stable(d_src_addr) && $stable(d_fill_color)));
   a_r9_no_take: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> !in_ready);
   // R6: an issued descriptor always has area
   a_r6_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> (!COORD_SIGNED || (($signed(d_dst_x2) > $signed(d_dst_x1))
         && ($signed(d_dst_y2) > $signed(d_dst_y1)))));
   // R7: an issued tiled surface is aligned
   a_r7_align: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && d_dst_tiled) |-> (d_dst_addr[TILE_ALIGN_LOG2-1:0] == '0));
   // R5: a tiled pitch is a multiple of the tile unit
   a_r5_tile_pitch: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && d_dst_tiled) |-> (d_dst_pitch[TILE_PITCH_LOG2-1:0] == '0));
   // R8: error pulses and a new descriptor never coincide
   a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_opcode, err_align, $rose(desc_valid)}));
   // R10: the input closes right after a packet's last word
   a_r10_close: assert property (@(posedge clk) disable iff (!rst_n)
      last_word |=> !in_ready);
endmodule

// File: tb/test_blit_pkt_decoder.sv
`timescale 1ns/1ps
module test_blit_pkt_decoder;
   localparam int CLK_PERIOD = 10;
   localparam int DV_W = 243;
   localparam logic [7:0] OPC_C = 8'hC3;
   localparam logic [7:0] OPC_F = 8'hA5;

   logic clk = 0, rst_n = 0;
   logic in_valid = 0, desc_ready = 0;
   logic [31:0] in_word = '0;
   logic in_ready, desc_valid, err_opcode, err_align;
   logic d_is_copy, d_wr_alpha, d_wr_rgb, d_src_tiled, d_dst_tiled;
   logic [7:0] d_rop; logic [1:0] d_depth;
   logic [17:0] d_dst_pitch, d_src_pitch;
   logic [15:0] d_dst_x1, d_dst_y1, d_dst_x2, d_dst_y2, d_src_x, d_src_y;
   logic [31:0] d_dst_addr, d_src_addr, d_fill_color;

   int total = 0, bad = 0, n_desc = 0, n_op = 0, n_al = 0, exp_op = 0, exp_al = 0;
   bit bp_en = 0;
   logic [DV_W-1:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   blit_pkt_decoder i_blit_pkt_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
      .desc_valid(desc_valid), .desc_ready(desc_ready), .d_is_copy(d_is_copy),
      .d_wr_alpha(d_wr_alpha), .d_wr_rgb(d_wr_rgb), .d_src_tiled(d_src_tiled),
      .d_dst_tiled(d_dst_tiled), .d_rop(d_rop), .d_depth(d_depth), .d_dst_pitch(d_dst_pitch),
      .d_dst_x1(d_dst_x1), .d_dst_y1(d_dst_y1), .d_dst_x2(d_dst_x2), .d_dst_y2(d_dst_y2),
      .d_dst_addr(d_dst_addr), .d_src_x(d_src_x), .d_src_y(d_src_y), .d_src_pitch(d_src_pitch),
      .d_src_addr(d_src_addr), .d_fill_color(d_fill_color), .err_opcode(err_opcode),
      .err_align(err_align));

   function automatic logic [DV_W-1:0] out_vec();
      return {d_is_copy, d_wr_alpha, d_wr_rgb, d_src_tiled, d_dst_tiled, d_rop, d_depth,
              d_dst_pitch, d_dst_x1, d_dst_y1, d_dst_x2, d_dst_y2, d_dst_addr,
              d_src_x, d_src_y, d_src_pitch, d_src_addr, d_fill_color};
   endfunction

   function automatic logic [17:0] pitch_exp(input logic [15:0] p, input logic t);
      logic signed [17:0] s;
      s = {{2{p[15]}}, p};
      return t ? 18'(s * 4) : s;
   endfunction

   // res: 0 descriptor, 1 dropped, 2 alignment error, 3 opcode error
   function automatic void model(input logic [31:0] w [8], output int res, output logic [DV_W-1:0] v);
      logic cp, st, dt;
      logic [15:0] sx, sy; logic [17:0] sp; logic [31:0] sa, col;
      v = '0;
      if (w[0][31:24] != OPC_C && w[0][31:24] != OPC_F) begin res = 3; return; end
      cp = (w[0][31:24] == OPC_C);
      st = cp & w[0][15]; dt = w[0][11];
      sx = cp ? w[5][15:0] : 16'h0;  sy = cp ? w[5][31:16] : 16'h0;
      sp = cp ? pitch_exp(w[6][15:0], st) : 18'h0;
      sa = cp ? w[7] : 32'h0;        col = cp ? 32'h0 : w[5];
      v = {cp, w[0][21], w[0][20], st, dt, w[1][23:16], w[1][25:24], pitch_exp(w[1][15:0], dt),
           w[2][15:0], w[2][31:16], w[3][15:0], w[3][31:16], w[4], sx, sy, sp, sa, col};
      if ((dt && w[4][11:0] != 0) || (st && sa[11:0] != 0)) res = 2;
      else if ($signed(w[3][15:0]) <= $signed(w[2][15:0]) ||
               $signed(w[3][31:16]) <= $signed(w[2][31:16])) res = 1;
      else res = 0;
   endfunction

   task automatic check(input bit ok, input string req, input logic [DV_W-1:0] act, input logic [DV_W-1:0] exp);
      total++;
      if (!ok) begin bad++; $display("FAIL %s act=%0h exp=%0h", req, act, exp); end
   endtask

   // monitor samples three quarters into the cycle, after the drivers have changed
   always begin
      @(negedge clk); #(CLK_PERIOD/4);
      if (rst_n) begin
         if (err_opcode) n_op++;
         if (err_align)  n_al++;
         if (desc_valid && desc_ready) begin
            logic [DV_W-1:0] e;
            n_desc++;
            if (exp_q.size() == 0) check(0, "R6 unexpected descriptor", out_vec(), '0);
            else begin
               e = exp_q.pop_front();
               check(out_vec() == e, e[DV_W-1] ? "R2 copy descriptor" : "R3 fill descriptor", out_vec(), e);
            end
         end
      end
   end

   always @(negedge clk) if (bp_en) desc_ready = ($urandom % 10) < 7;

   task automatic send_pkt(input logic [31:0] w [8], input int n);
      int res; logic [DV_W-1:0] v;
      model(w, res, v);
      if (res == 0) exp_q.push_back(v);
      else if (res == 2) exp_al++;
      else if (res == 3) exp_op++;
      for (int i = 0; i < n; i++) begin
         in_valid = 1; in_word = w[i];
         while (!in_ready) @(negedge clk);
         @(negedge clk);
      end
      in_valid = 0;
   endtask

   function automatic logic [31:0] cmd_word(input logic [7:0] opc, input logic a, input logic r,
                                            input logic st, input logic dt);
      logic [31:0] c;
      c = $urandom; c[31:24] = opc; c[21] = a; c[20] = r; c[15] = st; c[11] = dt;
      return c;
   endfunction

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] w [8];
      int nd;
      void'($urandom(32'h1234_5eed));
      wait_cyc(3);
      // R1: reset state
      check(desc_valid == 0 && in_ready == 1 && err_opcode == 0 && err_align == 0,
            "R1 reset state", {desc_valid, in_ready, err_opcode, err_align}, 4'b0100);
      rst_n = 1;
      wait_cyc(2);
      check(desc_valid == 0 && in_ready == 1, "R1 after reset", {desc_valid, in_ready}, 2'b01);

      // R10/R9/R5/R4: tiled copy held by backpressure
      desc_ready = 0;
      w[0] = cmd_word(OPC_C, 1, 1, 1, 1);
      w[1] = 32'h02CC_FF00;              // rop CC, depth 2, pitch -256
      w[2] = {16'd20, 16'd10};  w[3] = {16'd60, 16'd50};
      w[4] = 32'h0004_0000;     w[5] = {16'd7, 16'd3};
      w[6] = 32'h0000_0100;     w[7] = 32'h0010_0000;
      send_pkt(w, 8);
      check(desc_valid == 0 && in_ready == 0, "R10 one cycle after last word", {desc_valid, in_ready}, 2'b00);
      @(negedge clk);
      check(desc_valid == 1, "R10 valid after two edges", desc_valid, 1);
      wait_cyc(4);
      check(desc_valid == 1 && in_ready == 0, "R9 held under backpressure", {desc_valid, in_ready}, 2'b10);
      check(d_dst_pitch == 18'h3FC00, "R5 tiled negative pitch", d_dst_pitch, 18'h3FC00);
      check(d_src_pitch == 18'd1024, "R5 tiled source pitch", d_src_pitch, 18'd1024);
      check(d_dst_x1 == 16'd10 && d_dst_y1 == 16'd20 && d_rop == 8'hCC && d_depth == 2'd2,
            "R4 field positions", {d_dst_x1, d_dst_y1, d_rop, d_depth}, {16'd10, 16'd20, 8'hCC, 2'd2});
      desc_ready = 1;
      wait_cyc(3);

      // R3: fill with source-tiled bit set is not affected by it
      desc_ready = 0;
      w[0] = cmd_word(OPC_F, 0, 1, 1, 0);
      w[1] = 32'h01F0_0040; w[2] = {16'd0, 16'd0}; w[3] = {16'd4, 16'd4};
      w[4] = 32'h0000_0123; w[5] = 32'hDEAD_BEEF;
      send_pkt(w, 6);
      wait_cyc(2);
      check(d_fill_color == 32'hDEAD_BEEF && d_src_tiled == 0 && d_src_pitch == 0 && d_src_addr == 0,
            "R3 fill value and source zero", {d_fill_color, d_src_tiled, d_src_pitch},
            {32'hDEAD_BEEF, 1'b0, 18'h0});
      desc_ready = 1;
      wait_cyc(3);

      // R6: empty rectangles produce nothing
      nd = n_desc;
      w[0] = cmd_word(OPC_F, 1, 1, 0, 0); w[2] = {16'd5, 16'd9}; w[3] = {16'd8, 16'd9};
      send_pkt(w, 6);
      w[2] = {16'd5, 16'd1}; w[3] = {16'hFFFF, 16'd8};  // y2 = -1 < y1
      send_pkt(w, 6);
      wait_cyc(6);
      check(n_desc == nd && desc_valid == 0 && n_al == exp_al, "R6 empty dropped", n_desc, nd);

      // R7: misaligned tiled destination flagged even when the rectangle is empty
      w[0] = cmd_word(OPC_F, 1, 1, 0, 1); w[4] = 32'h0000_1010;
      send_pkt(w, 6);
      wait_cyc(4);
      check(n_al == 1 && n_desc == nd, "R7 align error priority", n_al, 1);

      // R8: unknown opcode then a valid fill
      w[0] = 32'h1200_0000;
      send_pkt(w, 1);
      w[0] = cmd_word(OPC_F, 0, 0, 0, 0); w[2] = {16'd1, 16'd1}; w[3] = {16'd2, 16'd2};
      w[4] = 32'h40; w[5] = 32'h5555_AAAA;
      send_pkt(w, 6);
      wait_cyc(4);
      check(n_op == 1 && n_desc == nd + 1, "R8 resync after bad opcode", {n_op, n_desc}, {32'd1, nd + 1});

      // random mix with backpressure
      bp_en = 1;
      for (int k = 0; k < 400; k++) begin
         int sel; logic cp, st, dt; logic [15:0] x1, y1;
         sel = $urandom % 20;
         if (sel == 0) begin
            w[0] = $urandom; if (w[0][31:24] == OPC_C || w[0][31:24] == OPC_F) w[0][31:24] = 8'h00;
            send_pkt(w, 1);
            continue;
         end
         cp = sel < 11; st = ($urandom % 3) == 0; dt = ($urandom % 3) == 0;
         w[0] = cmd_word(cp ? OPC_C : OPC_F, $urandom % 2, $urandom % 2, st, dt);
         w[1] = $urandom;
         x1 = 16'($urandom % 2000); y1 = 16'($urandom % 2000);
         w[2] = {y1, x1};
         w[3] = {16'(int'(y1) + int'($urandom % 60) - 3), 16'(int'(x1) + int'($urandom % 60) - 3)};
         w[4] = $urandom; if ($urandom % 4 != 0) w[4][11:0] = 0;
         w[5] = $urandom; w[6] = $urandom;
         w[7] = $urandom; if ($urandom % 4 != 0) w[7][11:0] = 0;
         send_pkt(w, cp ? 8 : 6);
      end
      bp_en = 0; desc_ready = 1;
      wait_cyc(20);
      check(exp_q.size() == 0, "R2 all descriptors delivered", exp_q.size(), 0);
      check(n_op == exp_op, "R8 opcode error count", n_op, exp_op);
      check(n_al == exp_al, "R7 align error count", n_al, exp_al);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule